// File: doc/BRIEF.md
# Serial Divider-Ratio Loader

This block takes configuration words for a dual frequency synthesizer over a three-wire serial port: a data line, a shift clock and a load strobe. It brings all three into the system clock domain and shifts one bit on each rising edge of the shift clock. On each rising edge of the load strobe it copies the assembled 23-bit word into one of four holding registers. The four registers are the transmit reference divider, the receive reference divider, the transmit main/swallow divider and the receive main/swallow divider.

Two control bits inside the word choose the target register. No separate select line does this. The control bits are the last bits shifted in. The held ratios, the charge-pump current select bits and the test bits drive the divider logic directly. A one-cycle update strobe per register tells that logic a new value has arrived. A word that carries an illegal ratio is dropped. The register it targets keeps its old value and raises no strobe.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, both reference ratios read 3, both main counts read 3, both swallow counts read 0, and all test, current-select and update outputs read 0.
- R2: The data line is sampled at each synchronized rising edge of the shift clock and enters the register at word bit 1, so a word sent most significant bit first ends up with its last-sent bit as bit 1.
- R3: A synchronized rising edge of the load strobe writes at most one holding register. With bit 1 as the first control bit and bit 2 as the second, the pairs (0,0), (1,0), (0,1) and (1,1) select transmit reference, receive reference, transmit main/swallow and receive main/swallow.
- R4: In a reference word, bits 3 and 4 are the test bits (bit 3 is test[0]), bits 5 to 18 are the 14-bit ratio with its LSB at bit 5, and bit 19 is the charge-pump current select.
- R5: In a main/swallow word, bits 3 to 9 are the 7-bit swallow count with its LSB at bit 3, and bits 10 to 20 are the 11-bit main count with its LSB at bit 10.
- R6: A reference load whose ratio is below 3 is rejected. The target register keeps its value and no strobe is raised.
- R7: A main/swallow load whose main count is below 3, or whose swallow count is not less than the main count, is rejected. The target register keeps its value and no strobe is raised.
- R8: Bits 20 to 23 of a reference word and bits 21 to 23 of a main/swallow word have no effect on any output.
- R9: Each accepted load raises the update strobe of its target register for exactly one system cycle, in the cycle the new value first appears. Update bit 0 is transmit reference, bit 1 receive reference, bit 2 transmit main/swallow and bit 3 receive main/swallow.
- R10: When a shift-clock edge and a load-strobe edge are detected in the same system cycle, the load takes the word as it stood before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, rising edge loads |
| tx_ref_ratio | output | 14 | Transmit reference divide ratio |
| tx_ref_test | output | 2 | Transmit reference test bits |
| tx_cp_sel | output | 1 | Transmit charge-pump current select |
| rx_ref_ratio | output | 14 | Receive reference divide ratio |
| rx_ref_test | output | 2 | Receive reference test bits |
| rx_cp_sel | output | 1 | Receive charge-pump current select |
| tx_main | output | 11 | Transmit main counter ratio |
| tx_swallow | output | 7 | Transmit swallow counter ratio |
| rx_main | output | 11 | Receive main counter ratio |
| rx_swallow | output | 7 | Receive swallow counter ratio |
| upd | output | 4 | One-cycle update strobes, one per register |

## Verification
A shift and a load can fall in the same system cycle when the shift clock and the load strobe rise together on the pins, because both then pass through synchronizers of equal depth. The bench raises both pins on the same instant after a full word has been shifted in. It expects the register to receive that complete word and not a word that already contains the newly sampled bit. It then shifts only 22 more bits and loads again. If the earlier shift took place, the bit sampled during the simultaneous edge becomes the top bit of the second word, and the bench checks the result against that expectation.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int REF_W   = 14,
  parameter int MAIN_W  = 11,
  parameter int SWL_W   = 7,
  parameter int CTL_W   = 2,
  parameter int TST_W   = 2,
  parameter int WORD_W  = 23,
  parameter int MIN_DIV = 3,
  parameter int RST_REF = 3,
  parameter int RST_MAIN = 3,
  parameter int RST_SWL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  tx_ref_ratio,
  output logic [TST_W-1:0]  tx_ref_test,
  output logic              tx_cp_sel,
  output logic [REF_W-1:0]  rx_ref_ratio,
  output logic [TST_W-1:0]  rx_ref_test,
  output logic              rx_cp_sel,
  output logic [MAIN_W-1:0] tx_main,
  output logic [SWL_W-1:0]  tx_swallow,
  output logic [MAIN_W-1:0] rx_main,
  output logic [SWL_W-1:0]  rx_swallow,
  output logic [3:0]        upd
);

  localparam int RATIO_LSB = CTL_W + TST_W;
  localparam int CP_POS    = RATIO_LSB + REF_W;
  localparam int SWL_LSB   = CTL_W;
  localparam int MAIN_LSB  = SWL_LSB + SWL_W;

  logic [2:0] ck_q, le_q;
  logic [1:0] dt_q;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= '0;
      le_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      le_q <= {le_q[1:0], ser_le};
      dt_q <= {dt_q[0], ser_data};
    end
  end

  wire shift_ev = ck_q[1] & ~ck_q[2];
  wire load_ev  = le_q[1] & ~le_q[2];

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (shift_ev) sr <= {sr[WORD_W-2:0], dt_q[1]};
  end

  wire [CTL_W-1:0]  sel      = sr[CTL_W-1:0];
  wire [REF_W-1:0]  w_ratio  = sr[CP_POS-1:RATIO_LSB];
  wire [TST_W-1:0]  w_test   = sr[RATIO_LSB-1:CTL_W];
  wire              w_cp     = sr[CP_POS];
  wire [SWL_W-1:0]  w_swl    = sr[MAIN_LSB-1:SWL_LSB];
  wire [MAIN_W-1:0] w_main   = sr[MAIN_LSB+MAIN_W-1:MAIN_LSB];
  wire ratio_ok = w_ratio >= REF_W'(MIN_DIV);
  wire na_ok    = (w_main >= MAIN_W'(MIN_DIV)) &&
                  ({{(MAIN_W-SWL_W){1'b0}}, w_swl} < w_main);

  logic [REF_W-1:0]  ref_q  [2];
  logic [TST_W-1:0]  tst_q  [2];
  logic              cp_q   [2];
  logic [MAIN_W-1:0] main_q [2];
  logic [SWL_W-1:0]  swl_q  [2];
  logic [3:0]        upd_q;

  for (genvar i = 0; i < 2; i++) begin : g_pair
    wire ld_ref = load_ev && ratio_ok && (sel == CTL_W'(i));
    wire ld_na  = load_ev && na_ok    && (sel == CTL_W'(i + 2));

    always_ff @(posedge clk) begin
      if (rst) begin
        ref_q[i]    <= REF_W'(RST_REF);
        tst_q[i]    <= '0;
        cp_q[i]     <= 1'b0;
        upd_q[i]    <= 1'b0;
      end else begin
        upd_q[i] <= ld_ref;
        if (ld_ref) begin
          ref_q[i] <= w_ratio;
          tst_q[i] <= w_test;
          cp_q[i]  <= w_cp;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        main_q[i]  <= MAIN_W'(RST_MAIN);
        swl_q[i]   <= SWL_W'(RST_SWL);
        upd_q[i+2] <= 1'b0;
      end else begin
        upd_q[i+2] <= ld_na;
        if (ld_na) begin
          main_q[i] <= w_main;
          swl_q[i]  <= w_swl;
        end
      end
    end

    AST_REF_FLOOR: assert property (@(posedge clk) disable iff (rst)
      ref_q[i] >= REF_W'(MIN_DIV)); // R6
    AST_NA_ORDER: assert property (@(posedge clk) disable iff (rst)
      (main_q[i] >= MAIN_W'(MIN_DIV)) && ({{(MAIN_W-SWL_W){1'b0}}, swl_q[i]} < main_q[i])); // R7
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd_q[i] |-> $stable({ref_q[i], tst_q[i], cp_q[i]})); // R9
    AST_NA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd_q[i+2] |-> $stable({main_q[i], swl_q[i]})); // R9
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_q)); // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    |upd_q |=> ~|upd_q); // R9

  assign tx_ref_ratio = ref_q[0];
  assign tx_ref_test  = tst_q[0];
  assign tx_cp_sel    = cp_q[0];
  assign rx_ref_ratio = ref_q[1];
  assign rx_ref_test  = tst_q[1];
  assign rx_cp_sel    = cp_q[1];
  assign tx_main      = main_q[0];
  assign tx_swallow   = swl_q[0];
  assign rx_main      = main_q[1];
  assign rx_swallow   = swl_q[1];
  assign upd          = upd_q;

endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_data = 0, ser_le = 0;
  logic [13:0] tx_ref_ratio, rx_ref_ratio;
  logic [1:0]  tx_ref_test, rx_ref_test;
  logic        tx_cp_sel, rx_cp_sel;
  logic [10:0] tx_main, rx_main;
  logic [6:0]  tx_swallow, rx_swallow;
  logic [3:0]  upd;

  cfg_serial_loader dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .tx_ref_ratio(tx_ref_ratio), .tx_ref_test(tx_ref_test), .tx_cp_sel(tx_cp_sel),
    .rx_ref_ratio(rx_ref_ratio), .rx_ref_test(rx_ref_test), .rx_cp_sel(rx_cp_sel),
    .tx_main(tx_main), .tx_swallow(tx_swallow), .rx_main(rx_main),
    .rx_swallow(rx_swallow), .upd(upd));

  always #2 clk = ~clk;

  int nvec = 0, nerr = 0;
  logic [16:0] e_ref [2];
  logic [17:0] e_na  [2];
  int cnt [4];

  function automatic logic [22:0] mk_ref(int idx, logic [1:0] t, logic [13:0] r, logic cp, logic [3:0] dc);
    return {dc, cp, r, t, idx[1:0]};
  endfunction

  function automatic logic [22:0] mk_na(int idx, logic [6:0] a, logic [10:0] n, logic [2:0] dc);
    return {dc, n, a, idx[1:0]};
  endfunction

  function automatic int model(logic [22:0] w);
    int idx = int'(w[1:0]);
    if (idx < 2) begin
      if (w[17:4] < 14'd3) return -1;
      e_ref[idx] = {w[18], w[17:4], w[3:2]};
      return idx;
    end
    if (w[19:9] < 11'd3 || {4'd0, w[8:2]} >= w[19:9]) return -1;
    e_na[idx-2] = {w[19:9], w[8:2]};
    return idx;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, 64'({tx_cp_sel, tx_ref_ratio, tx_ref_test}), 64'(e_ref[0]));
    chk(req, 64'({rx_cp_sel, rx_ref_ratio, rx_ref_test}), 64'(e_ref[1]));
    chk(req, 64'({tx_main, tx_swallow}), 64'(e_na[0]));
    chk(req, 64'({rx_main, rx_swallow}), 64'(e_na[1]));
  endtask

  task automatic chk_strobes(string req, int tgt);
    for (int k = 0; k < 4; k++) chk(req, 64'(cnt[k]), (k == tgt) ? 64'd1 : 64'd0);
  endtask

  task automatic count_cycles(int n);
    repeat (n) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (upd[k]) cnt[k]++;
    end
  endtask

  task automatic send_bit(logic b);
    ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1;
    repeat (3) @(negedge clk);
    ser_clk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bits(logic [22:0] w, int nb);
    for (int i = nb - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le();
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    ser_le = 1;
    count_cycles(8);
    ser_le = 0;
    count_cycles(4);
  endtask

  task automatic load(logic [22:0] w, string req);
    int tgt;
    send_bits(w, 23);
    pulse_le();
    tgt = model(w);
    chk_all(req);
    chk_strobes(req, tgt);
  endtask

  initial begin
    int wd;
    #2000000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [22:0] w, x;
    int tgt;
    void'($urandom(32'h1c0ffee));
    e_ref[0] = {1'b0, 14'd3, 2'b00};
    e_ref[1] = {1'b0, 14'd3, 2'b00};
    e_na[0]  = {11'd3, 7'd0};
    e_na[1]  = {11'd3, 7'd0};
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    chk("R1", 64'(upd), 64'd0);

    // R3 R4 R9 directed per target
    load(mk_ref(0, 2'b01, 14'd1234, 1'b1, 4'h0), "R3 R4 R9");
    load(mk_ref(1, 2'b10, 14'd16383, 1'b0, 4'hf), "R3 R4 R9");
    load(mk_na(2, 7'd5, 11'd100, 3'd0), "R3 R5 R9");
    load(mk_na(3, 7'd127, 11'd2047, 3'd7), "R3 R5 R9");
    // R6 boundaries
    load(mk_ref(0, 2'b11, 14'd2, 1'b0, 4'h0), "R6");
    load(mk_ref(1, 2'b00, 14'd0, 1'b1, 4'h0), "R6");
    load(mk_ref(0, 2'b00, 14'd3, 1'b0, 4'h0), "R6");
    // R7 boundaries
    load(mk_na(2, 7'd0, 11'd2, 3'd0), "R7");
    load(mk_na(3, 7'd40, 11'd40, 3'd0), "R7");
    load(mk_na(3, 7'd39, 11'd40, 3'd0), "R7");
    load(mk_na(2, 7'd0, 11'd3, 3'd0), "R7");
    // R8 only ignored bits differ
    load(mk_ref(1, 2'b01, 14'd777, 1'b1, 4'h0), "R8");
    load(mk_ref(1, 2'b01, 14'd777, 1'b1, 4'ha), "R8");
    load(mk_na(2, 7'd9, 11'd900, 3'd5), "R8");
    // R2 single bit walked through the ratio field
    load(mk_ref(0, 2'b00, 14'h2000, 1'b0, 4'h0), "R2");
    load(mk_ref(0, 2'b00, 14'h0004, 1'b0, 4'h0), "R2");

    // R10 simultaneous shift and load edges
    w = mk_ref(1, 2'b10, 14'd4321, 1'b1, 4'h3);
    x = mk_na(3, 7'd11, 11'd500, 3'b100);
    send_bits(w, 23);
    ser_data = x[22];
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    ser_clk = 1;
    ser_le = 1;
    count_cycles(8);
    ser_clk = 0;
    ser_le = 0;
    count_cycles(4);
    tgt = model(w);
    chk_all("R10");
    chk_strobes("R10", tgt);
    send_bits(x, 22);
    pulse_le();
    tgt = model(x);
    chk_all("R10");
    chk_strobes("R10", tgt);

    // R3 R4 R5 R6 R7 R8 R9 random words
    for (int n = 0; n < 150; n++) begin
      int idx = int'($urandom % 4);
      logic [13:0] r;
      logic [10:0] nn;
      logic [6:0] a;
      r  = ($urandom % 4 == 0) ? 14'($urandom % 5) : 14'($urandom);
      nn = ($urandom % 4 == 0) ? 11'($urandom % 5) : 11'($urandom);
      a  = ($urandom % 3 == 0) ? 7'(nn) : 7'($urandom);
      if (idx < 2) w = mk_ref(idx, 2'($urandom), r, 1'($urandom), 4'($urandom));
      else         w = mk_na(idx, a, nn, 3'($urandom));
      load(w, "R3-random R9 R8");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule